// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that pulls a system reset when software stops servicing it. A slow, free-running tick, presented as a one-clock enable `tick`, is divided by a programmable prescaler. Each prescaler step decrements a 12-bit down-counter. Software reaches the block only through a small synchronous register bus. It writes magic values to a key register to start the watchdog, to feed it, and to open the divider and reload registers for a write.

The bus is control-only. Every write is accepted in the cycle `wr_en` is high, and reads are combinational from `addr`. There is no valid/ready handshake and no back-pressure, because nothing streams through the block.

Register map (word address on `addr`): 0 = key (write-only, reads zero), 1 = divider code, 2 = reload value, 3 = status (read-only). A write to the key register counts as a key only when the whole data word equals the key value; any other word is treated as an "other" key.

Top module: `guard_timer`

## Requirements
- R1: Writing 0x0000CCCC to address 0 while idle raises `running` on the next cycle and restarts the prescaler. The counter begins counting from its current value, which is 0xFFF after reset.
- R2: Once `running` is high it stays high until `rst_n`. A further start key while running changes neither the count nor the prescaler phase.
- R3: Writing 0x0000AAAA to address 0 (feed) loads the active reload value into the counter and restarts the prescaler. The next timeout pulse then appears N*max(R,1) ticks after the feed, where N is the divide ratio and R is the reload value.
- R4: After reset, writes to addresses 1 and 2 are ignored: the stored value and the pending flags do not change.
- R5: Writing 0x00005555 to address 0 opens addresses 1 and 2 for writes. Any other word written to address 0, the feed key included, closes them again.
- R6: The reload register keeps bits 11:0 of a write and reads zero above. The divider register keeps bits 2:0 of a write and reads zero above.
- R7: Divider code c gives a divide ratio of 4<<c for c from 0 to 6. Code 7 gives 256, the same as code 6.
- R8: After reset, the divider reads 0, reload reads 0xFFF, status reads 0, address 0 reads 0, `running` and `wdt_rst` are low, and the counter holds 0xFFF.
- R9: An accepted write to address 1 or 2 sets a pending flag (status bit 0 for the divider, bit 1 for reload, also on `div_pend` and `rld_pend`). The next tick copies the new value into use and clears that flag.
- R10: Before the first start key the counter never decrements and `wdt_rst` stays low. A feed written while idle loads the counter but does not start it.
- R11: `wdt_rst` is a single-cycle pulse, raised in the cycle after a prescaler step finds the counter at 1 or 0. The counter then reloads 0xFFF and keeps running, so timeouts repeat.
- R12: A reload value of 0 times out on the very first prescaler step after a feed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| tick | input | 1 | One-cycle enable from the slow time base |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| wdt_rst | output | 1 | One-cycle timeout reset pulse |
| running | output | 1 | Watchdog has been started |
| div_pend | output | 1 | Divider update waiting for a tick |
| rld_pend | output | 1 | Reload update waiting for a tick |

## Verification
The timeout path is tried with several reload values (5, 2, 0 and the 0xFFF default) across divider codes 0, 2 and 7. Each measured pulse spacing separates the ratio table, the saturation at code 7, and the "counter at 1 or 0" terminal rule. A run of closely spaced feeds shows that feeding holds the pulse off. A start key written mid-count shows that it neither reloads the counter nor resets the prescaler, since either would change the measured delay. Key sequences with a foreign value, with the feed key and with no unlock at all tell the protection rules apart by reading the registers back, and the ticks are held off to observe the pending flags before they are applied.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int REG_AW = 2;
  localparam logic [15:0] KEY_START = 16'hCCCC;
  localparam logic [15:0] KEY_FEED  = 16'hAAAA;
  localparam logic [15:0] KEY_OPEN  = 16'h5555;

  typedef enum logic [REG_AW-1:0] {
    REG_KEY  = 2'd0,
    REG_DIV  = 2'd1,
    REG_RLD  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gt_keyctl.sv
module gt_keyctl
  import gt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              start_p,
  output logic              feed_p,
  output logic              unlocked,
  output logic [CODE_W-1:0] div_act,
  output logic [CNT_W-1:0]  rld_act,
  output logic              div_pend,
  output logic              rld_pend
);
  logic              key_wr, div_wr, rld_wr;
  logic [CODE_W-1:0] div_reg;
  logic [CNT_W-1:0]  rld_reg;

  // A key matches only when the whole data word equals it
  assign key_wr  = wr_en && (reg_sel_e'(addr) == REG_KEY);
  assign start_p = key_wr && (wr_data == DATA_W'(KEY_START));
  assign feed_p  = key_wr && (wr_data == DATA_W'(KEY_FEED));
  assign div_wr  = wr_en && unlocked && (reg_sel_e'(addr) == REG_DIV);
  assign rld_wr  = wr_en && unlocked && (reg_sel_e'(addr) == REG_RLD);

  // Protection gate: opened by the open key, closed by any other key word
  always_ff @(posedge clk) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (wr_data == DATA_W'(KEY_OPEN));
  end

  // Programmed values and their in-use copies, staged through a tick
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_reg  <= '0;
      rld_reg  <= '1;
      div_act  <= '0;
      rld_act  <= '1;
      div_pend <= 1'b0;
      rld_pend <= 1'b0;
    end else begin
      if (tick && div_pend) div_act <= div_reg;
      if (tick && rld_pend) rld_act <= rld_reg;
      if (div_wr) begin
        div_reg  <= wr_data[CODE_W-1:0];
        div_pend <= 1'b1;
      end else if (tick) begin
        div_pend <= 1'b0;
      end
      if (rld_wr) begin
        rld_reg  <= wr_data[CNT_W-1:0];
        rld_pend <= 1'b1;
      end else if (tick) begin
        rld_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(addr))
      REG_DIV:  rd_data[CODE_W-1:0] = div_reg;
      REG_RLD:  rd_data[CNT_W-1:0]  = rld_reg;
      REG_STAT: rd_data[1:0]        = {rld_pend, div_pend};
      default:  rd_data             = '0;
    endcase
  end
endmodule

// File: rtl/gt_presc.sv
module gt_presc #(
  parameter int CODE_W    = 3,
  parameter int BASE_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              clear,
  input  logic [CODE_W-1:0] code,
  output logic              step
);
  localparam int SHIFT_MAX = (1 << CODE_W) - 2;
  localparam int PRE_W     = BASE_LOG2 + SHIFT_MAX;

  logic [CODE_W-1:0] shift;
  logic [PRE_W-1:0]  term;
  logic [PRE_W-1:0]  pre;
  logic              at_end;

  // The top code saturates onto the one below it
  always_comb begin
    shift = (code > CODE_W'(SHIFT_MAX)) ? CODE_W'(SHIFT_MAX) : code;
  end

  // Terminal count is ratio-1: the low BASE_LOG2+shift bits set
  for (genvar i = 0; i < PRE_W; i++) begin : g_term
    assign term[i] = (i < (BASE_LOG2 + int'(shift)));
  end

  // ">=" keeps a shrinking divider from wrapping through the whole range
  assign at_end = (pre >= term);
  assign step   = run && tick && !clear && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  pre <= '0;
    else if (run && tick) pre <= at_end ? '0 : pre + 1'b1;
  end
endmodule

// File: rtl/gt_count.sv
module gt_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_p,
  input  logic             feed_p,
  input  logic             step,
  input  logic [CNT_W-1:0] rld_act,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             wdt_rst
);
  logic expire;

  // A step that finds 1 or 0 is the last one; a feed in that cycle wins
  assign expire = step && !feed_p && (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       running <= 1'b0;
    else if (start_p) running <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '1;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= expire;
      if (feed_p)      cnt <= rld_act;
      else if (expire) cnt <= '1;
      else if (step)   cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 12,
  parameter int CODE_W    = 3,
  parameter int BASE_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wdt_rst,
  output logic              running,
  output logic              div_pend,
  output logic              rld_pend
);
  logic              start_p, feed_p, unlocked, step, pre_clr;
  logic [CODE_W-1:0] div_act;
  logic [CNT_W-1:0]  rld_act;
  logic [CNT_W-1:0]  cnt;

  // Start restarts the phase only from idle; a feed always does
  assign pre_clr = feed_p || (start_p && !running);

  gt_keyctl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_key (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .start_p(start_p), .feed_p(feed_p),
    .unlocked(unlocked), .div_act(div_act), .rld_act(rld_act),
    .div_pend(div_pend), .rld_pend(rld_pend)
  );

  gt_presc #(.CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(running), .clear(pre_clr),
    .code(div_act), .step(step)
  );

  gt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .feed_p(feed_p), .step(step),
    .rld_act(rld_act), .cnt(cnt), .running(running), .wdt_rst(wdt_rst)
  );
endmodule

// File: rtl/gt_checker.sv
module gt_checker
  import gt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [REG_AW-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              wdt_rst,
  input logic              running,
  input logic              rld_pend,
  input logic              unlocked,
  input logic              start_p,
  input logic              feed_p,
  input logic [CNT_W-1:0]  rld_act,
  input logic [CNT_W-1:0]  cnt
);
  logic rld_hit;
  assign rld_hit = wr_en && (reg_sel_e'(addr) == REG_RLD);

  a_r1_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> running);
  a_r2_never_stops: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
  a_r3_feed_loads: assert property (@(posedge clk) disable iff (!rst_n)
    feed_p |=> (cnt == $past(rld_act)));
  a_r4_locked_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_hit && !unlocked && !rld_pend) |=> !rld_pend);
  a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel_e'(addr) == REG_KEY && wr_data != DATA_W'(KEY_OPEN)) |=> !unlocked);
  a_r6_rld_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_e'(addr) == REG_RLD) |-> (rd_data[DATA_W-1:CNT_W] == '0));
  a_r9_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_pend && tick && !(rld_hit && unlocked)) |=> !rld_pend);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !wdt_rst);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  a_r11_full_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (cnt == '1));
endmodule

bind guard_timer gt_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .wdt_rst(wdt_rst), .running(running),
  .rld_pend(rld_pend), .unlocked(unlocked), .start_p(start_p), .feed_p(feed_p),
  .rld_act(rld_act), .cnt(cnt)
);

// File: tb/sim_guard_timer.sv
module sim_guard_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wdt_rst, running, div_pend, rld_pend;

  guard_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .wdt_rst(wdt_rst), .running(running),
    .div_pend(div_pend), .rld_pend(rld_pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, n_chk = 0, n_bad = 0, seen = 0, mark = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  // Driver side of the scoreboard: a feed marks time zero, expectation queued
  task automatic feed_expect(input int n, input string req);
    wr(2'd0, 32'h0000_AAAA);
    mark = cyc;
    if (n > 0) begin exp_q.push_back(n); tag_q.push_back(req); end
  endtask

  task automatic wait_pulse();
    int s = seen;
    while (seen == s) @(negedge clk);
  endtask

  // Monitor: every pulse must match the next queued spacing
  always @(negedge clk) begin
    if (rst_n && wdt_rst) begin
      seen++;
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R3: actual unexpected pulse at %0d expected none", cyc);
      end else begin
        check(tag_q.pop_front(), cyc - mark, exp_q.pop_front());
      end
      mark = cyc;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    logic [DW-1:0] v;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    rd(2'd1, v); check("R8", v, 0);
    rd(2'd2, v); check("R8", v, 32'hFFF);
    rd(2'd3, v); check("R8", v, 0);
    rd(2'd0, v); check("R8", v, 0);
    check("R8", running, 0);
    check("R8", wdt_rst, 0);

    // R4 locked write ignored
    wr(2'd2, 32'd5);
    rd(2'd2, v); check("R4", v, 32'hFFF);
    check("R4", rld_pend, 0);

    // R6 / R9 unlocked write, truncation, pending until a tick
    wr(2'd0, 32'h0000_5555);
    wr(2'd2, 32'h0000_F005);
    rd(2'd2, v); check("R6", v, 32'h005);
    check("R9", rld_pend, 1);
    rd(2'd3, v); check("R9", v, 2);
    tick = 1'b1;
    @(negedge clk);
    check("R9", rld_pend, 0);
    rd(2'd3, v); check("R9", v, 0);

    // R5 foreign key closes the gate
    wr(2'd0, 32'h0000_5555);
    wr(2'd0, 32'h0000_1234);
    wr(2'd1, 32'd3);
    rd(2'd1, v); check("R5", v, 0);
    check("R5", div_pend, 0);

    // R5 feed key closes the gate; R10 idle feed loads, no start
    wr(2'd0, 32'h0000_5555);
    feed_expect(0, "R10");
    wr(2'd2, 32'd7);
    rd(2'd2, v); check("R5", v, 5);
    repeat (200) @(negedge clk);
    check("R10", running, 0);
    check("R10", seen, 0);

    // R1 start: 4*5 cycles, then R11 repeat from 0xFFF
    wr(2'd0, 32'h0000_CCCC);
    mark = cyc;
    exp_q.push_back(20); tag_q.push_back("R1");
    check("R1", running, 1);
    wait_pulse();
    exp_q.push_back(16380); tag_q.push_back("R11");
    wait_pulse();

    // R3 frequent feeds hold off the pulse
    s0 = seen;
    for (int i = 0; i < 15; i++) begin
      feed_expect(0, "R3");
      repeat (12) @(negedge clk);
    end
    check("R3", seen, s0);
    feed_expect(20, "R3");
    wait_pulse();

    // R2 start mid-count changes nothing
    feed_expect(20, "R2");
    repeat (6) @(negedge clk);
    wr(2'd0, 32'h0000_CCCC);
    check("R2", running, 1);
    wait_pulse();

    // R7 code 2 -> 16
    wr(2'd0, 32'h0000_5555);
    wr(2'd1, 32'd2);
    feed_expect(80, "R7");
    wait_pulse();

    // R6 code width, R7 code 7 saturates at 256
    wr(2'd0, 32'h0000_5555);
    wr(2'd1, 32'h0000_000E);
    rd(2'd1, v); check("R6", v, 6);
    wr(2'd1, 32'd7);
    wr(2'd2, 32'd2);
    feed_expect(512, "R7");
    wait_pulse();

    // R12 reload of zero fires on the first step
    wr(2'd0, 32'h0000_5555);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    feed_expect(4, "R12");
    wait_pulse();

    // R5 gate closed again after that feed
    wr(2'd2, 32'd9);
    rd(2'd2, v); check("R5", v, 0);

    report();
  end
endmodule